// File: doc/BRIEF.md
# Linked-List Descriptor Fetcher

This block lets one DMA channel run a chain of transfer configurations kept in memory instead of a single configuration written by software. A trigger starts the chain at the address held in a list-pointer input. The block reads the record found there one word at a time over a simple read port. It then hands the configuration words to the channel's working registers and serves the channel with transfer addresses until the channel reports that the transaction is complete. After that it follows the record's next pointer to the following record.

The chain is circular: the last record points back to the first. The block treats a next pointer equal to the starting address as the end of the list, so it never loads a record that was not meant to be used. While a transaction runs, the block steps the transfer address by a fixed stride. When the address equals the record's wrap limit, the next address is the record's wrap target instead. A read that returns an error response stops the chain and raises a sticky error flag.

A record is `REC_WORDS` words. Word 0 is the first transfer address, word 1 is the wrap limit, word 2 is the wrap target, and the last word is the next-record pointer. Any words between these are passed to the channel unchanged.

Top module: `desc_chain_fetcher`

## Requirements
- R1: After reset the block is idle. `busy_o`, `err_o`, `mem_req_valid_o`, `cfg_ld_valid_o`, `xfer_run_o`, `trans_done_o` and `list_done_o` are 0, and `xfer_addr_o` is 0.
- R2: A trigger (`start_i`) seen while idle captures `list_ptr_i` as the chain head. Word k of a record is requested at record address + k·(DW/8), in increasing k. The block has at most one read outstanding, holds each request stable until it is accepted, and issues the next request only after the response to the previous one.
- R3: Once all words of a record have been read, the block presents words 0 to REC_WORDS-2 on the load port, one word per cycle, in increasing index order, with `cfg_ld_idx_o` giving the word index.
- R4: In the cycle after the last load word, `xfer_run_o` rises and `xfer_addr_o` equals record word 0. Each cycle with `xfer_step_i` high during run advances the address by STRIDE bytes. `xfer_step_i` has no effect outside run.
- R5: A step taken while `xfer_addr_o` equals record word 1 (the wrap limit) sets the address to record word 2 (the wrap target) instead of adding the stride.
- R6: When `xfer_done_i` is high in a run cycle, run ends and `trans_done_o` pulses for exactly one cycle in the following cycle.
- R7: If the finished record's last word differs from the chain head, the block next fetches the record at that address.
- R8: If the finished record's last word equals the chain head, `list_done_o` pulses in the same cycle as `trans_done_o`, and the block returns to idle.
- R9: An error response (`mem_rsp_err_i` with `mem_rsp_valid_i`) while fetching returns the block to idle with `err_o` set and no load words for that record. `err_o` stays set until the next accepted trigger clears it.
- R10: `start_i` has no effect while the block is busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Trigger to begin the chain |
| list_ptr_i | input | DW | Address of the first record |
| mem_req_valid_o | output | 1 | Read request valid |
| mem_req_addr_o | output | DW | Read request byte address |
| mem_req_ready_i | input | 1 | Memory accepts the request |
| mem_rsp_valid_i | input | 1 | Read data returned |
| mem_rsp_data_i | input | DW | Returned word |
| mem_rsp_err_i | input | 1 | Returned word carries an error |
| cfg_ld_valid_o | output | 1 | Configuration word to the channel is valid |
| cfg_ld_idx_o | output | IDX_W | Index of the configuration word |
| cfg_ld_data_o | output | DW | Configuration word |
| xfer_run_o | output | 1 | Channel transaction in progress |
| xfer_step_i | input | 1 | Channel consumed the current address |
| xfer_addr_o | output | DW | Current transfer address |
| xfer_done_i | input | 1 | Channel finished the transaction |
| trans_done_o | output | 1 | One-cycle pulse per finished transaction |
| list_done_o | output | 1 | One-cycle pulse when the chain ends |
| busy_o | output | 1 | Chain in progress |
| err_o | output | 1 | Sticky fetch error flag |

## Verification
If the word counter or the outstanding-read flag is corrupted, the request address or request valid no longer matches the reference within one cycle of the next handshake. A corrupted record buffer shows up on the load port a few cycles later, and again as a wrong start address when run begins. An address generator that mixes up the limit and the target gives a wrong `xfer_addr_o` on the step that follows the limit. A wrong head register cannot be seen until the end of the chain: `list_done_o` is then missing or comes too early. For that reason the bench runs whole chains and counts the pulses.

// File: rtl/llf_pkg.sv
package llf_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_FETCH = 3'd1,
        ST_LOAD  = 3'd2,
        ST_RUN   = 3'd3,
        ST_NEXT  = 3'd4
    } llf_state_e;

    // Fixed positions of the fields the block itself decodes
    localparam int unsigned FLD_START     = 0;
    localparam int unsigned FLD_LIMIT     = 1;
    localparam int unsigned FLD_TARGET    = 2;
    localparam int unsigned MIN_REC_WORDS = 4;

    function automatic logic idx_is(input int unsigned idx, input int unsigned val);
        return idx == val;
    endfunction

endpackage

// File: rtl/llf_fetch.sv
module llf_fetch #(
    parameter int unsigned DW         = 32,
    parameter int unsigned REC_WORDS  = 4,
    parameter int unsigned WORD_BYTES = DW / 8,
    parameter int unsigned IW         = $clog2(REC_WORDS)
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           kick_i,
    input  logic [DW-1:0]                  base_i,
    output logic                           req_valid_o,
    output logic [DW-1:0]                  req_addr_o,
    input  logic                           req_ready_i,
    input  logic                           rsp_valid_i,
    input  logic [DW-1:0]                  rsp_data_i,
    input  logic                           rsp_err_i,
    output logic                           done_o,
    output logic                           err_o,
    output logic [REC_WORDS-1:0][DW-1:0]   rec_o
);
    localparam logic [IW-1:0] LAST_IDX = IW'(REC_WORDS - 1);

    logic          active_q;
    logic          wait_q;
    logic [IW-1:0] widx_q;
    logic [DW-1:0] base_q;
    logic          take;
    logic          last_word;

    assign take        = active_q & wait_q & rsp_valid_i;
    assign last_word   = (widx_q == LAST_IDX);
    assign done_o      = take & ~rsp_err_i & last_word;
    assign err_o       = take & rsp_err_i;
    assign req_valid_o = active_q & ~wait_q;
    assign req_addr_o  = base_q + DW'(widx_q) * DW'(WORD_BYTES);

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            wait_q   <= 1'b0;
            widx_q   <= '0;
            base_q   <= '0;
        end else if (kick_i) begin
            active_q <= 1'b1;
            wait_q   <= 1'b0;
            widx_q   <= '0;
            base_q   <= base_i;
        end else begin
            if (req_valid_o && req_ready_i) begin
                wait_q <= 1'b1;
            end
            if (take) begin
                wait_q <= 1'b0;
                if (rsp_err_i || last_word) begin
                    active_q <= 1'b0;
                end else begin
                    widx_q <= widx_q + 1'b1;
                end
            end
        end
    end

    // One capture register per record word
    for (genvar w = 0; w < REC_WORDS; w++) begin : g_word
        logic [DW-1:0] word_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                word_q <= '0;
            end else if (take && !rsp_err_i && widx_q == IW'(w)) begin
                word_q <= rsp_data_i;
            end
        end
        assign rec_o[w] = word_q;
    end

endmodule

// File: rtl/llf_addr_gen.sv
module llf_addr_gen #(
    parameter int unsigned DW     = 32,
    parameter int unsigned STRIDE = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load_i,
    input  logic [DW-1:0] start_i,
    input  logic [DW-1:0] limit_i,
    input  logic [DW-1:0] target_i,
    input  logic          step_i,
    output logic [DW-1:0] addr_o,
    output logic [DW-1:0] limit_o,
    output logic [DW-1:0] target_o
);
    logic [DW-1:0] addr_q;
    logic [DW-1:0] limit_q;
    logic [DW-1:0] target_q;
    logic [DW-1:0] addr_nxt;

    always_comb begin
        if (addr_q == limit_q) begin
            addr_nxt = target_q;
        end else begin
            addr_nxt = addr_q + DW'(STRIDE);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q   <= '0;
            limit_q  <= '0;
            target_q <= '0;
        end else if (load_i) begin
            addr_q   <= start_i;
            limit_q  <= limit_i;
            target_q <= target_i;
        end else if (step_i) begin
            addr_q   <= addr_nxt;
        end
    end

    assign addr_o   = addr_q;
    assign limit_o  = limit_q;
    assign target_o = target_q;

endmodule

// File: rtl/llf_seq.sv
module llf_seq
    import llf_pkg::*;
#(
    parameter int unsigned DW        = 32,
    parameter int unsigned REC_WORDS = 4,
    parameter int unsigned IW        = $clog2(REC_WORDS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_i,
    input  logic [DW-1:0] list_ptr_i,
    input  logic          fetch_done_i,
    input  logic          fetch_err_i,
    input  logic [DW-1:0] next_ptr_i,
    input  logic          xfer_done_i,
    output logic          kick_o,
    output logic [DW-1:0] base_o,
    output logic          ld_valid_o,
    output logic [IW-1:0] ld_idx_o,
    output logic          agen_load_o,
    output logic          run_o,
    output logic          trans_done_o,
    output logic          list_done_o,
    output logic          busy_o,
    output logic          err_o
);
    localparam logic [IW-1:0] LAST_LD = IW'(REC_WORDS - 2);

    llf_state_e    st_q;
    llf_state_e    st_nxt;
    logic [DW-1:0] head_q;
    logic [IW-1:0] lidx_q;
    logic          err_q;
    logic          chain_end;

    assign chain_end = (next_ptr_i == head_q);

    always_comb begin
        st_nxt      = st_q;
        kick_o      = 1'b0;
        base_o      = next_ptr_i;
        agen_load_o = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                base_o = list_ptr_i;
                if (start_i) begin
                    kick_o = 1'b1;
                    st_nxt = ST_FETCH;
                end
            end
            ST_FETCH: begin
                if (fetch_err_i) begin
                    st_nxt = ST_IDLE;
                end else if (fetch_done_i) begin
                    st_nxt = ST_LOAD;
                end
            end
            ST_LOAD: begin
                if (lidx_q == LAST_LD) begin
                    agen_load_o = 1'b1;
                    st_nxt      = ST_RUN;
                end
            end
            ST_RUN: begin
                if (xfer_done_i) begin
                    st_nxt = ST_NEXT;
                end
            end
            ST_NEXT: begin
                if (chain_end) begin
                    st_nxt = ST_IDLE;
                end else begin
                    kick_o = 1'b1;
                    st_nxt = ST_FETCH;
                end
            end
            default: st_nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            head_q <= '0;
            lidx_q <= '0;
            err_q  <= 1'b0;
        end else begin
            st_q <= st_nxt;
            if (st_q == ST_IDLE && start_i) begin
                head_q <= list_ptr_i;
                err_q  <= 1'b0;
            end
            if (st_q == ST_FETCH && fetch_err_i) begin
                err_q <= 1'b1;
            end
            if (st_q == ST_LOAD) begin
                lidx_q <= (lidx_q == LAST_LD) ? '0 : lidx_q + 1'b1;
            end
        end
    end

    assign ld_valid_o   = (st_q == ST_LOAD);
    assign ld_idx_o     = lidx_q;
    assign run_o        = (st_q == ST_RUN);
    assign trans_done_o = (st_q == ST_NEXT);
    assign list_done_o  = (st_q == ST_NEXT) & chain_end;
    assign busy_o       = (st_q != ST_IDLE);
    assign err_o        = err_q;

endmodule

// File: rtl/desc_chain_fetcher.sv
module desc_chain_fetcher
    import llf_pkg::*;
#(
    parameter int unsigned DW        = 32,
    parameter int unsigned REC_WORDS = 4,
    parameter int unsigned STRIDE    = 4,
    localparam int unsigned IDX_W    = $clog2(REC_WORDS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [DW-1:0]    list_ptr_i,
    output logic             mem_req_valid_o,
    output logic [DW-1:0]    mem_req_addr_o,
    input  logic             mem_req_ready_i,
    input  logic             mem_rsp_valid_i,
    input  logic [DW-1:0]    mem_rsp_data_i,
    input  logic             mem_rsp_err_i,
    output logic             cfg_ld_valid_o,
    output logic [IDX_W-1:0] cfg_ld_idx_o,
    output logic [DW-1:0]    cfg_ld_data_o,
    output logic             xfer_run_o,
    input  logic             xfer_step_i,
    output logic [DW-1:0]    xfer_addr_o,
    input  logic             xfer_done_i,
    output logic             trans_done_o,
    output logic             list_done_o,
    output logic             busy_o,
    output logic             err_o
);
    logic                         kick;
    logic [DW-1:0]                base;
    logic                         fetch_done;
    logic                         fetch_err;
    logic [REC_WORDS-1:0][DW-1:0] rec;
    logic                         agen_load;
    logic [DW-1:0]                wrap_lim;
    logic [DW-1:0]                wrap_tgt;

    llf_fetch #(
        .DW        (DW),
        .REC_WORDS (REC_WORDS),
        .WORD_BYTES(DW / 8),
        .IW        (IDX_W)
    ) u_fetch (
        .clk        (clk),
        .rst        (rst),
        .kick_i     (kick),
        .base_i     (base),
        .req_valid_o(mem_req_valid_o),
        .req_addr_o (mem_req_addr_o),
        .req_ready_i(mem_req_ready_i),
        .rsp_valid_i(mem_rsp_valid_i),
        .rsp_data_i (mem_rsp_data_i),
        .rsp_err_i  (mem_rsp_err_i),
        .done_o     (fetch_done),
        .err_o      (fetch_err),
        .rec_o      (rec)
    );

    llf_seq #(
        .DW       (DW),
        .REC_WORDS(REC_WORDS),
        .IW       (IDX_W)
    ) u_seq (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start_i),
        .list_ptr_i  (list_ptr_i),
        .fetch_done_i(fetch_done),
        .fetch_err_i (fetch_err),
        .next_ptr_i  (rec[REC_WORDS-1]),
        .xfer_done_i (xfer_done_i),
        .kick_o      (kick),
        .base_o      (base),
        .ld_valid_o  (cfg_ld_valid_o),
        .ld_idx_o    (cfg_ld_idx_o),
        .agen_load_o (agen_load),
        .run_o       (xfer_run_o),
        .trans_done_o(trans_done_o),
        .list_done_o (list_done_o),
        .busy_o      (busy_o),
        .err_o       (err_o)
    );

    llf_addr_gen #(
        .DW    (DW),
        .STRIDE(STRIDE)
    ) u_agen (
        .clk     (clk),
        .rst     (rst),
        .load_i  (agen_load),
        .start_i (rec[FLD_START]),
        .limit_i (rec[FLD_LIMIT]),
        .target_i(rec[FLD_TARGET]),
        .step_i  (xfer_step_i & xfer_run_o),
        .addr_o  (xfer_addr_o),
        .limit_o (wrap_lim),
        .target_o(wrap_tgt)
    );

    assign cfg_ld_data_o = rec[cfg_ld_idx_o];

endmodule

// File: rtl/dcf_checker.sv
module dcf_checker #(
    parameter int unsigned DW        = 32,
    parameter int unsigned REC_WORDS = 4,
    parameter int unsigned IDX_W     = 2
) (
    input logic             clk,
    input logic             rst,
    input logic             mem_req_valid_o,
    input logic [DW-1:0]    mem_req_addr_o,
    input logic             mem_req_ready_i,
    input logic             cfg_ld_valid_o,
    input logic [IDX_W-1:0] cfg_ld_idx_o,
    input logic             xfer_run_o,
    input logic             xfer_step_i,
    input logic [DW-1:0]    xfer_addr_o,
    input logic             trans_done_o,
    input logic             list_done_o,
    input logic             busy_o,
    input logic             err_o,
    input logic [DW-1:0]    wrap_lim,
    input logic [DW-1:0]    wrap_tgt
);
    localparam logic [IDX_W-1:0] LAST_LD = IDX_W'(REC_WORDS - 2);

    p_req_hold_r2: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid_o && !mem_req_ready_i |=> mem_req_valid_o && $stable(mem_req_addr_o));

    p_req_gap_r2: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid_o && mem_req_ready_i |=> !mem_req_valid_o);

    p_load_order_r3: assert property (@(posedge clk) disable iff (rst)
        cfg_ld_valid_o && cfg_ld_idx_o != LAST_LD
        |=> cfg_ld_valid_o && cfg_ld_idx_o == $past(cfg_ld_idx_o) + 1'b1);

    p_load_then_run_r4: assert property (@(posedge clk) disable iff (rst)
        cfg_ld_valid_o && cfg_ld_idx_o == LAST_LD |=> xfer_run_o);

    p_addr_hold_r4: assert property (@(posedge clk) disable iff (rst)
        xfer_run_o && !xfer_step_i |=> $stable(xfer_addr_o));

    p_wrap_jump_r5: assert property (@(posedge clk) disable iff (rst)
        xfer_run_o && xfer_step_i && xfer_addr_o == wrap_lim |=> xfer_addr_o == $past(wrap_tgt));

    p_trans_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        trans_done_o |=> !trans_done_o);

    p_list_with_trans_r8: assert property (@(posedge clk) disable iff (rst)
        list_done_o |-> trans_done_o);

    p_list_to_idle_r8: assert property (@(posedge clk) disable iff (rst)
        list_done_o |=> !busy_o);

    p_err_idle_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(err_o) |-> !busy_o);

endmodule

bind desc_chain_fetcher dcf_checker #(
    .DW       (DW),
    .REC_WORDS(REC_WORDS),
    .IDX_W    (IDX_W)
) u_dcf_checker (
    .clk            (clk),
    .rst            (rst),
    .mem_req_valid_o(mem_req_valid_o),
    .mem_req_addr_o (mem_req_addr_o),
    .mem_req_ready_i(mem_req_ready_i),
    .cfg_ld_valid_o (cfg_ld_valid_o),
    .cfg_ld_idx_o   (cfg_ld_idx_o),
    .xfer_run_o     (xfer_run_o),
    .xfer_step_i    (xfer_step_i),
    .xfer_addr_o    (xfer_addr_o),
    .trans_done_o   (trans_done_o),
    .list_done_o    (list_done_o),
    .busy_o         (busy_o),
    .err_o          (err_o),
    .wrap_lim       (wrap_lim),
    .wrap_tgt       (wrap_tgt)
);

// File: tb/desc_chain_fetcher_bench.sv
`timescale 1ns/1ps
module desc_chain_fetcher_bench;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start_i = 1'b0;
    logic [DW-1:0] list_ptr_i = '0;
    logic          mem_req_valid_o;
    logic [DW-1:0] mem_req_addr_o;
    logic          mem_req_ready_i = 1'b0;
    logic          mem_rsp_valid_i = 1'b0;
    logic [DW-1:0] mem_rsp_data_i = '0;
    logic          mem_rsp_err_i = 1'b0;
    logic          cfg_ld_valid_o;
    logic [1:0]    cfg_ld_idx_o;
    logic [DW-1:0] cfg_ld_data_o;
    logic          xfer_run_o;
    logic          xfer_step_i = 1'b0;
    logic [DW-1:0] xfer_addr_o;
    logic          xfer_done_i = 1'b0;
    logic          trans_done_o;
    logic          list_done_o;
    logic          busy_o;
    logic          err_o;

    desc_chain_fetcher u_desc_chain_fetcher (.*);

    always #2 clk = ~clk;

    int errors = 0;
    int checks = 0;
    int n_trans = 0;
    int n_list = 0;
    int n_load = 0;
    bit finished = 0;

    logic [31:0] mem [int unsigned];
    longint err_addr = -1;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic put_rec(input int unsigned b, input logic [31:0] w0, input logic [31:0] w1,
                           input logic [31:0] w2, input logic [31:0] w3);
        mem[b] = w0; mem[b + 4] = w1; mem[b + 8] = w2; mem[b + 12] = w3;
    endtask

    // Inputs seen by the design at each rising edge
    logic s_rst, s_start, s_ready, s_rv, s_rerr, s_step, s_done;
    logic [31:0] s_ptr, s_rdata;
    always @(posedge clk) begin
        s_rst = rst; s_start = start_i; s_ptr = list_ptr_i; s_ready = mem_req_ready_i;
        s_rv = mem_rsp_valid_i; s_rerr = mem_rsp_err_i; s_rdata = mem_rsp_data_i;
        s_step = xfer_step_i; s_done = xfer_done_i;
    end

    // Behavioural reference: phase 0 idle, 1 reading, 2 handing over, 3 running, 4 finishing
    int phase = 0;
    int word_no = 0;
    int hand_no = 0;
    bit in_flight = 0;
    bit m_err = 0;
    logic [31:0] head = 0, recaddr = 0, cur = 0, lim = 0, tgt = 0;
    logic [31:0] words [4];

    initial begin
        foreach (words[i]) words[i] = 0;
        forever begin
            @(negedge clk);
            if (s_rst) begin
                phase = 0; m_err = 0; cur = 0; lim = 0; tgt = 0;
                word_no = 0; hand_no = 0; in_flight = 0;
            end else begin
                case (phase)
                    0: if (s_start) begin
                        head = s_ptr; recaddr = s_ptr; word_no = 0; in_flight = 0;
                        m_err = 0; phase = 1;
                    end
                    1: begin
                        if (!in_flight) begin
                            if (s_ready) in_flight = 1;
                        end else if (s_rv) begin
                            in_flight = 0;
                            if (s_rerr) begin
                                m_err = 1; phase = 0;
                            end else begin
                                words[word_no] = s_rdata;
                                if (word_no == 3) begin phase = 2; hand_no = 0; end
                                else word_no++;
                            end
                        end
                    end
                    2: begin
                        if (hand_no == 2) begin
                            phase = 3; cur = words[0]; lim = words[1]; tgt = words[2];
                        end
                        hand_no = (hand_no == 2) ? 0 : hand_no + 1;
                    end
                    3: begin
                        if (s_step) cur = (cur == lim) ? tgt : cur + 4;
                        if (s_done) phase = 4;
                    end
                    default: begin
                        if (words[3] == head) phase = 0;
                        else begin recaddr = words[3]; word_no = 0; in_flight = 0; phase = 1; end
                    end
                endcase
            end
            if (trans_done_o) n_trans++;
            if (list_done_o) n_list++;
            if (cfg_ld_valid_o) n_load++;
            check("R2 req_valid", mem_req_valid_o, (phase == 1 && !in_flight));
            if (phase == 1 && !in_flight)
                check("R2 req_addr", mem_req_addr_o, recaddr + 4 * word_no);
            check("R3 ld_valid", cfg_ld_valid_o, phase == 2);
            if (phase == 2) begin
                check("R3 ld_idx", cfg_ld_idx_o, hand_no);
                check("R3 ld_data", cfg_ld_data_o, words[hand_no]);
            end
            check("R4 run", xfer_run_o, phase == 3);
            check("R4/R5 xfer_addr", xfer_addr_o, cur);
            check("R6 trans_done", trans_done_o, phase == 4);
            check("R8 list_done", list_done_o, phase == 4 && words[3] == head);
            check("R10 busy", busy_o, phase != 0);
            check("R9 err", err_o, m_err);
        end
    end

    // Memory responder with varying ready and latency
    initial begin
        bit accepted = 0;
        bit pending = 0;
        int wait_cnt = 0;
        int tick = 0;
        logic [31:0] acc_addr = 0;
        logic [31:0] p_addr = 0;
        forever begin
            @(negedge clk);
            tick++;
            mem_rsp_valid_i = 1'b0;
            mem_rsp_err_i = 1'b0;
            if (accepted) begin
                pending = 1; p_addr = acc_addr; wait_cnt = tick % 2;
            end
            if (pending) begin
                if (wait_cnt == 0) begin
                    mem_rsp_valid_i = 1'b1;
                    mem_rsp_data_i = mem.exists(p_addr) ? mem[p_addr] : 32'hdead_0000;
                    mem_rsp_err_i = (longint'(p_addr) == err_addr);
                    pending = 0;
                end else wait_cnt--;
            end
            mem_req_ready_i = (tick % 3) != 1;
            accepted = mem_req_valid_o && mem_req_ready_i && !rst;
            acc_addr = mem_req_addr_o;
        end
    end

    task automatic kick(input logic [31:0] p);
        list_ptr_i = p; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic wait_run();
        while (!xfer_run_o) @(negedge clk);
    endtask

    task automatic run_xfer(input int n, input int gap, input bit merge);
        wait_run();
        for (int i = 0; i < n; i++) begin
            xfer_step_i = 1'b1; @(negedge clk); xfer_step_i = 1'b0;
            repeat (gap) @(negedge clk);
        end
        xfer_done_i = 1'b1; xfer_step_i = merge;
        @(negedge clk);
        xfer_done_i = 1'b0; xfer_step_i = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy_o) @(negedge clk);
    endtask

    task automatic finish_run();
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: actual hung expected finish");
            finish_run();
        end
    end

    initial begin
        int t0, l0, d0;
        put_rec(32'h100, 32'h2000, 32'h2008, 32'h2000, 32'h200);
        put_rec(32'h200, 32'h3000, 32'h3010, 32'h3004, 32'h300);
        put_rec(32'h300, 32'h4000, 32'h4004, 32'h3ff0, 32'h100);
        put_rec(32'h400, 32'h1000, 32'h1008, 32'h1000, 32'h400);
        put_rec(32'h500, 32'h5000, 32'h5004, 32'h5000, 32'h500);
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: idle after reset
        check("R1 busy", busy_o, 0);
        check("R1 err", err_o, 0);
        check("R1 req_valid", mem_req_valid_o, 0);
        check("R1 xfer_addr", xfer_addr_o, 0);
        check("R1 pulses", {trans_done_o, list_done_o, xfer_run_o, cfg_ld_valid_o}, 0);

        // Three-record circular chain; R10 extra trigger and stray step while busy
        t0 = n_trans; l0 = n_list;
        kick(32'h100);
        list_ptr_i = 32'h400; start_i = 1'b1; xfer_step_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0; xfer_step_i = 1'b0;
        run_xfer(5, 0, 0);
        run_xfer(3, 1, 1);
        run_xfer(4, 2, 0);
        wait_idle();
        check("R7 transactions in chain", n_trans - t0, 3);
        check("R8 list_done count", n_list - l0, 1);
        check("R10 head kept despite busy trigger", n_load, 9);

        // R5: wrap from limit to target, then done together with a step
        t0 = n_trans;
        kick(32'h400);
        wait_run();
        check("R4 first address", xfer_addr_o, 32'h1000);
        repeat (3) begin
            xfer_step_i = 1'b1; @(negedge clk);
        end
        xfer_step_i = 1'b0;
        check("R5 wrapped address", xfer_addr_o, 32'h1000);
        xfer_done_i = 1'b1; xfer_step_i = 1'b1;
        @(negedge clk);
        xfer_done_i = 1'b0; xfer_step_i = 1'b0;
        check("R6 trans_done pulse", trans_done_o, 1);
        check("R8 single-record list_done", list_done_o, 1);
        wait_idle();

        // R9: error on word 2 of a record
        err_addr = 32'h508;
        d0 = n_load;
        kick(32'h500);
        wait_idle();
        check("R9 err set", err_o, 1);
        check("R9 no load words", n_load - d0, 0);
        err_addr = -1;
        repeat (3) @(negedge clk);
        check("R9 err sticky", err_o, 1);

        // R9: next trigger clears the flag
        kick(32'h400);
        check("R9 err cleared", err_o, 0);
        run_xfer(2, 0, 0);
        wait_idle();
        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule